// File: doc/BRIEF.md
# Decimation Phase Sync Pulse Generator

This block keeps the decimation phases of three cascaded filter stages coherent across several chips: a first integrator-comb stage, a second integrator-comb stage and a final FIR decimator. Every stage has a phase counter that free-runs at its own decimation factor. The block turns these counters into per-stage decimation strobes. A stage-1 strobe comes once every first-factor clocks. A stage-2 strobe comes on every second-factor-th stage-1 strobe. A FIR strobe comes on every FIR-factor-th stage-2 strobe. So a slower strobe always falls on a cycle where the faster strobes also fire.

Two sync lines join chips together: one for the integrator-comb stages and one for the FIR stage. Each line is an output, an output enable and an input, and a pad cell outside the block merges them. A role input picks the mode. As master, the block counts clocks, drives periodic pulses onto both lines and enables its drivers. As slave, it turns its drivers off and only listens. In both modes the pulse that comes back from the pad is registered once and then re-aligns the phase counters. A master therefore locks to its own pulse in exactly the way its slaves do. The decimation factors are static configuration inputs, and a factor of 0 acts as 1.

Top module: `decim_sync_gen`

## Requirements
- R1: While rst_n is low, pad_cic_out and pad_fir_out are 0. After reset every phase counter and the master pulse counters start at phase 0, so all three strobes are high in the first cycle after reset.
- R2: pad_cic_oe and pad_fir_oe equal role_master: 1 selects master and drives the pads, 0 selects slave and three-states them.
- R3: In master mode pad_cic_out is high for one cycle every A×B clocks, where A = fac_cic1 and B = fac_cic2. The first pulse comes in the first cycle after the first rising edge following reset release.
- R4: In master mode pad_fir_out is high on the first pad_cic_out pulse and on every C-th pulse after it, where C = fac_fir. It is never high without pad_cic_out.
- R5: A high level on pad_cic_in in cycle n makes stb_cic1 and stb_cic2 both high in cycle n+1. After that, stb_cic1 fires every A cycles and stb_cic2 every A×B cycles.
- R6: With no sync pulses, stb_cic1 fires every A cycles. stb_cic2 fires on every B-th stb_cic1, and stb_fir fires on every C-th stb_cic2. stb_fir implies stb_cic2, and stb_cic2 implies stb_cic1.
- R7: A high level on pad_fir_in in cycle n resets the FIR phase. stb_fir then fires on the first stb_cic2 in cycle n+1 or later, and on every C-th stb_cic2 after that. The two integrator-comb strobes are not affected.
- R8: In master mode the block re-aligns on its own pulse: stb_cic2 is high exactly one cycle after each pad_cic_out pulse, and stb_fir exactly one cycle after each pad_fir_out pulse.
- R9: A factor of 0 or 1 gives a period of 1. With all factors at 0 or 1, every strobe is high in every cycle and a master drives both pads high in every cycle after the first.
- R10: In slave mode external pulses are accepted at any phase. The CIC and FIR lines are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything changes and is sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| role_master | input | 1 | 1 = master (drive pads), 0 = slave (listen) |
| fac_cic1 | input | FW | First integrator-comb decimation factor A |
| fac_cic2 | input | FW | Second integrator-comb decimation factor B |
| fac_fir | input | FW | FIR decimation factor C |
| pad_cic_in | input | 1 | CIC sync level seen at the pad |
| pad_fir_in | input | 1 | FIR sync level seen at the pad |
| pad_cic_out | output | 1 | CIC sync pulse driven toward the pad |
| pad_fir_out | output | 1 | FIR sync pulse driven toward the pad |
| pad_cic_oe | output | 1 | Driver enable for the CIC sync pad |
| pad_fir_oe | output | 1 | Driver enable for the FIR sync pad |
| stb_cic1 | output | 1 | First integrator-comb decimation strobe |
| stb_cic2 | output | 1 | Second integrator-comb decimation strobe |
| stb_fir | output | 1 | FIR decimation strobe |

## Verification
The bench injects a CIC sync pulse at a phase where no strobe would fall naturally. A design that ignored the pulse, or took an extra register stage to act on it, would leave its strobes on the old grid. It then sends a lone FIR pulse between stage-2 strobes. A design that fired the FIR strobe at once, or waited a full FIR period, would miss the expected cycle. In master mode, the pad pulses come back through a model of the pad cell. A master that did not re-align on its own pulse would show stage-2 strobes away from the cycle after each pad pulse. Factors of 0 and 1 are exercised too: a counter that underflows at those values would drop strobes that should fire in every cycle.

// File: rtl/decim_sync_pkg.sv
package decim_sync_pkg;

    // Role selected by the configuration bit
    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } sync_role_e;

    // The two sync lines handled together
    typedef struct packed {
        logic cic;
        logic fir;
    } sync_pair_t;

endpackage

// File: rtl/dsync_pulse_master.sv
module dsync_pulse_master
    import decim_sync_pkg::*;
#(
    parameter int unsigned FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] fac_a,
    input  logic [FW-1:0] fac_b,
    input  logic [FW-1:0] fac_c,
    output sync_pair_t    pulse_o
);
    localparam int unsigned PW = 2 * FW;

    typedef struct packed {
        logic [PW-1:0] gcnt;
        logic [FW-1:0] fcnt;
        sync_pair_t    pulse;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic [FW-1:0] a_eff, b_eff, c_lim;
    logic [PW-1:0] prod, p_lim;
    logic          gen_cic, gen_fir;

    always_comb begin
        a_eff   = (fac_a == '0) ? FW'(1) : fac_a;
        b_eff   = (fac_b == '0) ? FW'(1) : fac_b;
        c_lim   = (fac_c == '0) ? '0 : fac_c - FW'(1);
        prod    = PW'(a_eff) * PW'(b_eff);
        p_lim   = prod - PW'(1);
        gen_cic = (st_q.gcnt == '0);
        gen_fir = gen_cic && (st_q.fcnt == '0);

        st_d           = st_q;
        st_d.gcnt      = (st_q.gcnt >= p_lim) ? '0 : st_q.gcnt + PW'(1);
        if (gen_cic) begin
            st_d.fcnt  = (st_q.fcnt >= c_lim) ? '0 : st_q.fcnt + FW'(1);
        end
        st_d.pulse.cic = gen_cic;
        st_d.pulse.fir = gen_fir;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;

    // FIR pulse only rides on a CIC pulse
    assert_fir_on_cic_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o.fir |-> pulse_o.cic);

    // A pulse with a period above one is never followed by another at once
    assert_cic_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o.cic && p_lim != '0 && $stable(p_lim)) |=> !pulse_o.cic);

endmodule

// File: rtl/dsync_capture.sv
module dsync_capture
    import decim_sync_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sync_pair_t pad_i,
    output sync_pair_t sync_o
);
    localparam int unsigned NL = $bits(sync_pair_t);

    logic [NL-1:0] cap_d, cap_q;
    logic [NL-1:0] pad_v;

    assign pad_v = pad_i;

    // One register per pad line
    for (genvar gi = 0; gi < NL; gi++) begin : g_line
        always_comb begin
            cap_d[gi] = pad_v[gi];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cap_q[gi] <= 1'b0;
            end else begin
                cap_q[gi] <= cap_d[gi];
            end
        end
    end

    assign sync_o = cap_q;

endmodule

// File: rtl/dsync_phase_stage.sv
module dsync_phase_stage #(
    parameter int unsigned FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] fac,
    input  logic          adv,
    input  logic          resync,
    output logic          stb
);
    typedef struct packed {
        logic [FW-1:0] cnt;
    } ph_state_t;

    ph_state_t st_d, st_q;

    logic [FW-1:0] lim;
    logic [FW-1:0] eff;

    always_comb begin
        lim  = (fac == '0) ? '0 : fac - FW'(1);
        // A resync places the stage at phase zero in this very cycle
        eff  = resync ? '0 : st_q.cnt;
        stb  = adv && (eff == '0);
        st_d = st_q;
        if (adv) begin
            st_d.cnt = (eff >= lim) ? '0 : eff + FW'(1);
        end else begin
            st_d.cnt = eff;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/decim_sync_gen.sv
module decim_sync_gen
    import decim_sync_pkg::*;
#(
    parameter int unsigned FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          role_master,
    input  logic [FW-1:0] fac_cic1,
    input  logic [FW-1:0] fac_cic2,
    input  logic [FW-1:0] fac_fir,
    input  logic          pad_cic_in,
    input  logic          pad_fir_in,
    output logic          pad_cic_out,
    output logic          pad_fir_out,
    output logic          pad_cic_oe,
    output logic          pad_fir_oe,
    output logic          stb_cic1,
    output logic          stb_cic2,
    output logic          stb_fir
);
    sync_role_e role;
    sync_pair_t gen_pulse;
    sync_pair_t pad_seen;
    sync_pair_t sync_q;
    logic [FW-1:0] lim_a;

    assign role = sync_role_e'(role_master);

    dsync_pulse_master #(.FW(FW)) u_master (
        .clk     (clk),
        .rst_n   (rst_n),
        .fac_a   (fac_cic1),
        .fac_b   (fac_cic2),
        .fac_c   (fac_fir),
        .pulse_o (gen_pulse)
    );

    assign pad_cic_out = gen_pulse.cic;
    assign pad_fir_out = gen_pulse.fir;
    assign pad_cic_oe  = (role == ROLE_MASTER);
    assign pad_fir_oe  = (role == ROLE_MASTER);

    // The pad level is used in both roles
    assign pad_seen.cic = pad_cic_in;
    assign pad_seen.fir = pad_fir_in;

    dsync_capture u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_i  (pad_seen),
        .sync_o (sync_q)
    );

    dsync_phase_stage #(.FW(FW)) u_stage_cic1 (
        .clk    (clk),
        .rst_n  (rst_n),
        .fac    (fac_cic1),
        .adv    (1'b1),
        .resync (sync_q.cic),
        .stb    (stb_cic1)
    );

    dsync_phase_stage #(.FW(FW)) u_stage_cic2 (
        .clk    (clk),
        .rst_n  (rst_n),
        .fac    (fac_cic2),
        .adv    (stb_cic1),
        .resync (sync_q.cic),
        .stb    (stb_cic2)
    );

    dsync_phase_stage #(.FW(FW)) u_stage_fir (
        .clk    (clk),
        .rst_n  (rst_n),
        .fac    (fac_fir),
        .adv    (stb_cic2),
        .resync (sync_q.fir),
        .stb    (stb_fir)
    );

    assign lim_a = (fac_cic1 == '0) ? '0 : fac_cic1 - FW'(1);

    // Slower strobes always sit on faster ones
    assert_fir_nested_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stb_fir |-> stb_cic2);
    assert_cic2_nested_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stb_cic2 |-> stb_cic1);

    // A registered CIC pad pulse fires both CIC strobes
    assert_resync_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q.cic |-> (stb_cic1 && stb_cic2));

    // First-stage strobe cannot repeat at once unless its period is one or a resync hits
    assert_cic1_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_cic1 && lim_a != '0 && $stable(lim_a)) |=> (!stb_cic1 || sync_q.cic));

endmodule

// File: tb/test_decim_sync_gen.sv
module test_decim_sync_gen;
    localparam int unsigned FW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          role_master = 1'b0;
    logic [FW-1:0] fac_cic1 = 8'd1;
    logic [FW-1:0] fac_cic2 = 8'd1;
    logic [FW-1:0] fac_fir = 8'd1;
    logic          ext_cic = 1'b0;
    logic          ext_fir = 1'b0;
    logic          pad_cic_in, pad_fir_in;
    logic          pad_cic_out, pad_fir_out, pad_cic_oe, pad_fir_oe;
    logic          stb_cic1, stb_cic2, stb_fir;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    // Pad cell model: driver wins when enabled
    assign pad_cic_in = pad_cic_oe ? pad_cic_out : ext_cic;
    assign pad_fir_in = pad_fir_oe ? pad_fir_out : ext_fir;

    decim_sync_gen #(.FW(FW)) i_decim_sync_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .role_master (role_master),
        .fac_cic1    (fac_cic1),
        .fac_cic2    (fac_cic2),
        .fac_fir     (fac_fir),
        .pad_cic_in  (pad_cic_in),
        .pad_fir_in  (pad_fir_in),
        .pad_cic_out (pad_cic_out),
        .pad_fir_out (pad_fir_out),
        .pad_cic_oe  (pad_cic_oe),
        .pad_fir_oe  (pad_fir_oe),
        .stb_cic1    (stb_cic1),
        .stb_cic2    (stb_cic2),
        .stb_fir     (stb_fir)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Reset with a given setup; leaves the bench at sample k=0
    task automatic do_reset(input bit m, input int a, input int b, input int c);
        ext_cic     = 1'b0;
        ext_fir     = 1'b0;
        role_master = m;
        fac_cic1    = FW'(a);
        fac_cic2    = FW'(b);
        fac_fir     = FW'(c);
        rst_n       = 1'b0;
        repeat (3) @(posedge clk);
        step();
        chk(pad_cic_out == 1'b0, "R1 pad_cic_out in reset", pad_cic_out, 0);
        chk(pad_fir_out == 1'b0, "R1 pad_fir_out in reset", pad_fir_out, 0);
        chk(pad_cic_oe == m, "R2 pad_cic_oe", pad_cic_oe, m);
        chk(pad_fir_oe == m, "R2 pad_fir_oe", pad_fir_oe, m);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic strobes(input string tag, input bit e1, input bit e2, input bit e3);
        chk(stb_cic1 == e1, {tag, " stb_cic1"}, stb_cic1, e1);
        chk(stb_cic2 == e2, {tag, " stb_cic2"}, stb_cic2, e2);
        chk(stb_fir == e3, {tag, " stb_fir"}, stb_fir, e3);
    endtask

    // Slave, no pulses: free-running grid from reset
    task automatic t_slave_freerun();
        do_reset(1'b0, 2, 3, 2);
        for (int k = 0; k < 60; k++) begin
            strobes("R1 R6 R10 freerun", (k % 2) == 0, (k % 6) == 0, (k % 12) == 0);
            step();
        end
    endtask

    // Slave, CIC and FIR pulse at an off-grid phase
    task automatic t_slave_sync();
        do_reset(1'b0, 3, 2, 2);
        for (int k = 0; k < 45; k++) begin
            if (k < 5) begin
                strobes("R6 pre-sync", (k % 3) == 0, (k % 6) == 0, (k % 12) == 0);
            end else begin
                strobes("R5 R10 post-sync", ((k - 5) % 3) == 0, ((k - 5) % 6) == 0,
                        ((k - 5) % 12) == 0);
            end
            ext_cic = (k == 4);
            ext_fir = (k == 4);
            step();
        end
    endtask

    // Slave, lone FIR pulse between stage-2 strobes
    task automatic t_fir_only();
        do_reset(1'b0, 1, 2, 3);
        for (int k = 0; k < 24; k++) begin
            if (k < 3) begin
                strobes("R6 pre-fir-sync", 1'b1, (k % 2) == 0, k == 0);
            end else begin
                strobes("R7 fir-sync", 1'b1, (k % 2) == 0, (k >= 4) && (((k - 4) % 6) == 0));
            end
            ext_fir = (k == 2);
            step();
        end
    endtask

    // Master: own pulses drive the pads and re-align the stages
    task automatic t_master();
        do_reset(1'b1, 2, 2, 3);
        for (int k = 0; k < 50; k++) begin
            chk(pad_cic_out == ((k >= 1) && (((k - 1) % 4) == 0)), "R3 pad_cic_out",
                pad_cic_out, (k >= 1) && (((k - 1) % 4) == 0));
            chk(pad_fir_out == ((k >= 1) && (((k - 1) % 12) == 0)), "R4 pad_fir_out",
                pad_fir_out, (k >= 1) && (((k - 1) % 12) == 0));
            if (k >= 2) begin
                strobes("R8 master", (k % 2) == 0, ((k - 2) % 4) == 0, ((k - 2) % 12) == 0);
            end
            chk(pad_cic_oe == 1'b1, "R2 master oe", pad_cic_oe, 1);
            step();
        end
    endtask

    // Factors of 0 and 1: period one everywhere
    task automatic t_unit_factors();
        do_reset(1'b1, 0, 1, 0);
        for (int k = 0; k < 16; k++) begin
            strobes("R9 unit", 1'b1, 1'b1, 1'b1);
            if (k >= 1) begin
                chk(pad_cic_out == 1'b1, "R9 pad_cic_out unit", pad_cic_out, 1);
                chk(pad_fir_out == 1'b1, "R9 pad_fir_out unit", pad_fir_out, 1);
            end
            step();
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        t_slave_freerun();
        t_slave_sync();
        t_fir_only();
        t_master();
        t_unit_factors();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule